// File: doc/BRIEF.md
# Pipelined Single-Precision Float to Signed Integer Converter

This block turns 32-bit IEEE-754 single-precision operands into 32-bit signed two's-complement integers. An operand may be presented on every clock while the enable input is high, and the matching integer appears on the output two clock edges later. Results then follow at one per clock. When enable is low, every pipeline register keeps its contents, so the output and the flags stay frozen.

The first stage sorts the operand into one of five classes: zero, subnormal, normal, infinity or NaN. It shifts the significand against the unbiased exponent into an integer part, a guard bit and a sticky bit, and registers this information. The second stage rounds to nearest with ties to even, restores the sign and saturates out-of-range values. It then registers the result word together with three status flags: overflow, underflow and invalid. Each flag lines up with the data word of the same operand.

Top module: `f2i_conv`

## Requirements
- R1: For a finite operand whose rounded value fits the signed 32-bit range, data_o is that rounded value in two's complement and no flag is set.
- R2: A result appears on data_o and the flags after the second rising edge on which the operand's path was enabled: the operand is sampled at edge k with en high, and the result is visible after edge k+1 if en is high there too. A new operand is accepted on every enabled edge.
- R3: When en is low at a rising edge, neither pipeline stage changes, so data_o and all flags keep their values.
- R4: Rounding is to nearest. An exact halfway fraction goes to the even integer, so 2.5 gives 2, 3.5 gives 4 and -2.5 gives -2.
- R5: If the rounded magnitude does not fit, ovf_o is 1 and data_o saturates to 0x7FFFFFFF for a positive operand or 0x80000000 for a negative one.
- R6: The operand -2^31 (0xCF000000) gives 0x80000000 with no flag set.
- R7: Any NaN, and infinity of either sign (exponent field bits 30:23 all ones), sets inv_o and forces data_o to 0x80000000.
- R8: A nonzero operand that rounds to zero sets udf_o with data_o equal to 0. This covers subnormals and normals below one half, including exactly 0.5.
- R9: +0 and -0 give data_o equal to 0 with no flag set.
- R10: A synchronous reset (rst high at a rising edge) clears both stages, so data_o and all flags read 0 afterwards.
- R11: At most one of ovf_o, udf_o and inv_o is set in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advances the pipeline when high |
| data_i | input | 32 | Single-precision operand |
| data_o | output | 32 | Signed integer result |
| ovf_o | output | 1 | Result saturated because it is out of range |
| udf_o | output | 1 | Nonzero operand rounded to zero |
| inv_o | output | 1 | Operand was NaN or infinity |

## Verification
The bench builds the converter with its default parameters: an 8-bit exponent, a 23-bit fraction and a 32-bit integer. With these widths all 256 exponent codes are reachable from a 32-bit random word. Random operands biased towards exponents near the integer range reach both saturation edges and the transition from aligned to fully shifted-out fractions. A generator of exact halves places the tie bit at every shift distance, which exercises ties-to-even at each alignment position.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

    // Operand classes passed from the first stage to the second.
    typedef enum logic [2:0] {
        CL_ZERO = 3'd0,
        CL_SUB  = 3'd1,
        CL_NORM = 3'd2,
        CL_INF  = 3'd3,
        CL_NAN  = 3'd4
    } f2i_cls_e;

endpackage

// File: rtl/f2i_classify.sv
module f2i_classify
    import f2i_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] op_i,
    output logic                 sign_o,
    output logic [EXP_W-1:0]     exp_o,
    output logic [MAN_W-1:0]     man_o,
    output f2i_cls_e             cls_o
);

    localparam int OP_W = EXP_W + MAN_W + 1;

    logic exp_zero;
    logic exp_ones;
    logic man_zero;

    assign sign_o   = op_i[OP_W-1];
    assign exp_o    = op_i[OP_W-2:MAN_W];
    assign man_o    = op_i[MAN_W-1:0];
    assign exp_zero = (exp_o == '0);
    assign exp_ones = &exp_o;
    assign man_zero = (man_o == '0);

    always_comb begin
        unique case ({exp_ones, exp_zero})
            2'b01:   cls_o = man_zero ? CL_ZERO : CL_SUB;
            2'b10:   cls_o = man_zero ? CL_INF  : CL_NAN;
            default: cls_o = CL_NORM;
        endcase
    end

endmodule

// File: rtl/f2i_align.sv
module f2i_align
    import f2i_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int INT_W = 32
) (
    input  f2i_cls_e         cls_i,
    input  logic [EXP_W-1:0] exp_i,
    input  logic [MAN_W-1:0] man_i,
    output logic [INT_W-1:0] ipart_o,
    output logic             guard_o,
    output logic             sticky_o,
    output logic             big_o,
    output logic             at_min_o
);

    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int SIG_W  = MAN_W + 1;
    localparam int WIDE_W = 2 * INT_W;
    localparam int SH_OFS = INT_W - MAN_W;
    localparam int TOP_E  = INT_W - 1;

    int                e_val;
    logic [SIG_W-1:0]  sig;
    logic [WIDE_W-1:0] wide;

    assign sig = {1'b1, man_i};

    // Integer part in the upper half of wide, fraction in the lower half.
    always_comb begin
        e_val    = int'(exp_i) - BIAS;
        wide     = '0;
        ipart_o  = '0;
        guard_o  = 1'b0;
        sticky_o = 1'b0;
        big_o    = 1'b0;
        at_min_o = 1'b0;
        unique case (cls_i)
            CL_NORM: begin
                if (e_val >= TOP_E) begin
                    big_o    = 1'b1;
                    at_min_o = (e_val == TOP_E) && (man_i == '0);
                end else if (e_val >= -1) begin
                    wide     = {{(WIDE_W-SIG_W){1'b0}}, sig} << (e_val + SH_OFS);
                    ipart_o  = wide[WIDE_W-1:INT_W];
                    guard_o  = wide[INT_W-1];
                    sticky_o = |wide[INT_W-2:0];
                end else begin
                    sticky_o = 1'b1;
                end
            end
            CL_SUB:  sticky_o = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/f2i_compose.sv
module f2i_compose
    import f2i_pkg::*;
#(
    parameter int INT_W = 32
) (
    input  logic             sign_i,
    input  f2i_cls_e         cls_i,
    input  logic [INT_W-1:0] ipart_i,
    input  logic             guard_i,
    input  logic             sticky_i,
    input  logic             big_i,
    input  logic             at_min_i,
    output logic [INT_W-1:0] data_o,
    output logic             ovf_o,
    output logic             udf_o,
    output logic             inv_o
);

    localparam logic [INT_W-1:0] MAX_POS = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] MIN_NEG = {1'b1, {(INT_W-1){1'b0}}};

    logic             inc;
    logic [INT_W:0]   mag;
    logic             too_big;

    // Ties to even: round up when above half, or exactly half with an odd LSB.
    assign inc     = guard_i & (sticky_i | ipart_i[0]);
    assign mag     = {1'b0, ipart_i} + {{INT_W{1'b0}}, inc};
    assign too_big = sign_i ? (mag > {1'b0, MIN_NEG}) : (mag > {1'b0, MAX_POS});

    always_comb begin
        data_o = '0;
        ovf_o  = 1'b0;
        udf_o  = 1'b0;
        inv_o  = 1'b0;
        unique case (cls_i)
            CL_INF, CL_NAN: begin
                data_o = MIN_NEG;
                inv_o  = 1'b1;
            end
            CL_SUB, CL_NORM: begin
                if (big_i) begin
                    if (sign_i && at_min_i) begin
                        data_o = MIN_NEG;
                    end else begin
                        ovf_o  = 1'b1;
                        data_o = sign_i ? MIN_NEG : MAX_POS;
                    end
                end else if (mag == '0) begin
                    udf_o = 1'b1;
                end else if (too_big) begin
                    ovf_o  = 1'b1;
                    data_o = sign_i ? MIN_NEG : MAX_POS;
                end else begin
                    data_o = sign_i ? (~mag[INT_W-1:0] + 1'b1) : mag[INT_W-1:0];
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/f2i_conv.sv
module f2i_conv
    import f2i_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int INT_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic [EXP_W+MAN_W:0] data_i,
    output logic [INT_W-1:0]     data_o,
    output logic                 ovf_o,
    output logic                 udf_o,
    output logic                 inv_o
);

    typedef struct packed {
        logic             sign;
        f2i_cls_e         cls;
        logic [INT_W-1:0] ipart;
        logic             guard;
        logic             sticky;
        logic             big;
        logic             at_min;
    } st1_t;

    typedef struct packed {
        logic [INT_W-1:0] data;
        logic             ovf;
        logic             udf;
        logic             inv;
    } st2_t;

    logic             c_sign;
    logic [EXP_W-1:0] c_exp;
    logic [MAN_W-1:0] c_man;
    f2i_cls_e         c_cls;
    st1_t             st1_d;
    st1_t             st1_q;
    st2_t             st2_d;
    st2_t             st2_q;

    f2i_classify #(
        .EXP_W (EXP_W),
        .MAN_W (MAN_W)
    ) u_classify (
        .op_i   (data_i),
        .sign_o (c_sign),
        .exp_o  (c_exp),
        .man_o  (c_man),
        .cls_o  (c_cls)
    );

    f2i_align #(
        .EXP_W (EXP_W),
        .MAN_W (MAN_W),
        .INT_W (INT_W)
    ) u_align (
        .cls_i    (c_cls),
        .exp_i    (c_exp),
        .man_i    (c_man),
        .ipart_o  (st1_d.ipart),
        .guard_o  (st1_d.guard),
        .sticky_o (st1_d.sticky),
        .big_o    (st1_d.big),
        .at_min_o (st1_d.at_min)
    );

    assign st1_d.sign = c_sign;
    assign st1_d.cls  = c_cls;

    // Stage 1 register: classified and aligned operand.
    always_ff @(posedge clk) begin
        if (rst) begin
            st1_q <= '0;
        end else if (en) begin
            st1_q <= st1_d;
        end
    end

    f2i_compose #(
        .INT_W (INT_W)
    ) u_compose (
        .sign_i   (st1_q.sign),
        .cls_i    (st1_q.cls),
        .ipart_i  (st1_q.ipart),
        .guard_i  (st1_q.guard),
        .sticky_i (st1_q.sticky),
        .big_i    (st1_q.big),
        .at_min_i (st1_q.at_min),
        .data_o   (st2_d.data),
        .ovf_o    (st2_d.ovf),
        .udf_o    (st2_d.udf),
        .inv_o    (st2_d.inv)
    );

    // Stage 2 register: rounded result and flags.
    always_ff @(posedge clk) begin
        if (rst) begin
            st2_q <= '0;
        end else if (en) begin
            st2_q <= st2_d;
        end
    end

    assign data_o = st2_q.data;
    assign ovf_o  = st2_q.ovf;
    assign udf_o  = st2_q.udf;
    assign inv_o  = st2_q.inv;

endmodule

// File: rtl/f2i_conv_chk.sv
module f2i_conv_chk #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int INT_W = 32
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 en,
    input logic [EXP_W+MAN_W:0] data_i,
    input logic [INT_W-1:0]     data_o,
    input logic                 ovf_o,
    input logic                 udf_o,
    input logic                 inv_o
);

    localparam logic [INT_W-1:0] MAX_POS = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] MIN_NEG = {1'b1, {(INT_W-1){1'b0}}};

    // Set when the previous edge saw reset low.
    logic warm_q = 1'b0;
    always_ff @(posedge clk) warm_q <= !rst;

    assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ovf_o, udf_o, inv_o}));

    assert_invalid_value_R7: assert property (@(posedge clk) disable iff (rst)
        inv_o |-> (data_o == MIN_NEG));

    assert_underflow_zero_R8: assert property (@(posedge clk) disable iff (rst)
        udf_o |-> (data_o == '0));

    assert_overflow_saturate_R5: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> ((data_o == MAX_POS) || (data_o == MIN_NEG)));

    assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(data_o) && $stable(ovf_o) && $stable(udf_o) && $stable(inv_o)));

    assert_reset_clears_R10: assert property (@(posedge clk)
        rst |=> ((data_o == '0) && !ovf_o && !udf_o && !inv_o));

    assert_special_latency_R2: assert property (@(posedge clk) disable iff (rst)
        (warm_q && en && $past(en) && (&$past(data_i[EXP_W+MAN_W-1:MAN_W]))) |=> inv_o);

    assert_zero_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (warm_q && en && $past(en) && ($past(data_i[EXP_W+MAN_W-1:0]) == '0))
        |=> ((data_o == '0) && !ovf_o && !udf_o && !inv_o));

endmodule

bind f2i_conv f2i_conv_chk #(
    .EXP_W (EXP_W),
    .MAN_W (MAN_W),
    .INT_W (INT_W)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .data_i (data_i),
    .data_o (data_o),
    .ovf_o  (ovf_o),
    .udf_o  (udf_o),
    .inv_o  (inv_o)
);

// File: tb/tb_f2i_conv.sv
module tb_f2i_conv;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [31:0] data_i = '0;
    logic [31:0] data_o;
    logic        ovf_o, udf_o, inv_o;

    int    n_chk = 0;
    int    n_err = 0;
    string phase = "";

    always #5 clk = ~clk;

    f2i_conv dut (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .data_i (data_i),
        .data_o (data_o),
        .ovf_o  (ovf_o),
        .udf_o  (udf_o),
        .inv_o  (inv_o)
    );

    // Reference conversion, result packed as {ovf, udf, inv, data}.
    function automatic logic [34:0] ref_conv(input logic [31:0] x, output string tag);
        logic        sgn;
        int          ex, e, sh;
        longint      sig, q, rem, half;
        logic [31:0] r;
        sgn = x[31];
        ex  = int'(x[30:23]);
        tag = "R1";
        if (ex == 255) begin
            tag = "R7";
            return {3'b001, 32'h8000_0000};
        end
        if (x[30:0] == 31'd0) begin
            tag = "R9";
            return '0;
        end
        if (ex == 0) begin
            tag = "R8";
            return {3'b010, 32'h0};
        end
        e   = ex - 127;
        sig = longint'({1'b1, x[22:0]});
        if (e >= 31) begin
            if (sgn && e == 31 && x[22:0] == 23'd0) begin
                tag = "R6";
                return {3'b000, 32'h8000_0000};
            end
            tag = "R5";
            return {3'b100, sgn ? 32'h8000_0000 : 32'h7FFF_FFFF};
        end
        if (e >= 23) begin
            q = sig << (e - 23);
        end else if (e >= -1) begin
            sh   = 23 - e;
            q    = sig >> sh;
            rem  = sig - (q << sh);
            half = longint'(1) << (sh - 1);
            if (rem == half) tag = "R4";
            if (rem > half || (rem == half && q[0])) q = q + 1;
        end else begin
            q = 0;
        end
        if (q == 0) begin
            tag = "R8";
            return {3'b010, 32'h0};
        end
        if ((!sgn && q > 64'sd2147483647) || (sgn && q > 64'sd2147483648)) begin
            tag = "R5";
            return {3'b100, sgn ? 32'h8000_0000 : 32'h7FFF_FFFF};
        end
        r = sgn ? 32'(-q) : 32'(q);
        return {3'b000, r};
    endfunction

    // Bench pipeline model of operands; a reset operand is +0.
    logic [31:0] m1 = '0, m2 = '0;
    logic        held = 1'b0;
    always @(posedge clk) begin
        if (rst) begin
            m1 <= '0;
            m2 <= '0;
        end else if (en) begin
            m2 <= m1;
            m1 <= data_i;
        end
        held <= !en && !rst;
    end

    task automatic check_out();
        logic [34:0] expv, got;
        string       t, tag;
        expv = ref_conv(m2, t);
        tag  = (phase != "") ? phase : (held ? "R3" : t);
        got  = {ovf_o, udf_o, inv_o, data_o};
        n_chk++;
        if (got !== expv) begin
            n_err++;
            $display("FAIL %s op=%h got flags=%b data=%h expected flags=%b data=%h",
                     tag, m2, got[34:32], got[31:0], expv[34:32], expv[31:0]);
        end
        n_chk++;
        if ($countones({ovf_o, udf_o, inv_o}) > 1) begin
            n_err++;
            $display("FAIL R11 flags=%b expected at most one set", {ovf_o, udf_o, inv_o});
        end
    endtask

    task automatic drive(input logic [31:0] x, input logic e);
        @(negedge clk);
        check_out();
        data_i = x;
        en     = e;
    endtask

    function automatic logic [31:0] rand_op();
        logic [31:0] r, v;
        int          k, sel;
        r   = $urandom;
        sel = int'(r[2:0]);
        v   = $urandom;
        case (sel)
            0, 1, 2: v[30:23] = 8'(100 + ($urandom % 62));
            3: begin
                k = 1 + int'($urandom % 23);
                v[30:23] = 8'(127 + 23 - k);
                v[22:0]  = (v[22:0] & ~23'((32'd1 << k) - 1)) | 23'(32'd1 << (k - 1));
            end
            4: v[30:23] = 8'(156 + ($urandom % 4));
            5: v[30:23] = ($urandom % 2 == 0) ? 8'hFF : 8'h00;
            default: ;
        endcase
        return v;
    endfunction

    initial begin
        logic [31:0] dir [22];
        void'($urandom(32'd4242));
        dir = '{32'h3F80_0000, 32'h4020_0000, 32'h4060_0000, 32'hC020_0000,
                32'h3F00_0000, 32'h3F40_0000, 32'h3E80_0000, 32'h0000_0001,
                32'h0000_0000, 32'h8000_0000, 32'h4F00_0000, 32'hCF00_0000,
                32'hCF00_0001, 32'h4EFF_FFFF, 32'h7F80_0000, 32'hFF80_0000,
                32'h7FC0_0000, 32'hFFFF_FFFF, 32'hBF00_0000, 32'h3FC0_0000,
                32'hC2F6_8000, 32'h807F_FFFF};

        // R10: reset state
        repeat (3) @(negedge clk);
        phase = "R10";
        check_out();
        rst = 1'b0;

        // R2: fill latency, one result per clock
        phase = "R2";
        drive(32'h3F80_0000, 1'b1);
        drive(32'h4040_0000, 1'b1);
        drive(32'h40A0_0000, 1'b1);
        drive(32'h40E0_0000, 1'b1);
        drive(32'h0, 1'b1);
        phase = "";

        // Directed corners R4 R5 R6 R7 R8 R9
        foreach (dir[i]) drive(dir[i], 1'b1);
        drive(32'h0, 1'b1);
        drive(32'h0, 1'b1);

        // R3: enable low holds the pipeline
        drive(32'h4120_0000, 1'b1);
        drive(32'hC1A0_0000, 1'b1);
        for (int i = 0; i < 6; i++) drive(rand_op(), 1'b0);
        drive(32'h0, 1'b1);
        drive(32'h0, 1'b1);

        // Random stream with random enable
        for (int i = 0; i < 4000; i++) drive(rand_op(), ($urandom % 5) != 0);

        // R10: reset in the middle of traffic
        drive(32'h4F00_0000, 1'b1);
        drive(32'h7F80_0000, 1'b1);
        @(negedge clk);
        check_out();
        rst   = 1'b1;
        phase = "R10";
        drive(32'h3F80_0000, 1'b1);
        drive(32'h3F80_0000, 1'b1);
        rst   = 1'b0;
        phase = "";
        drive(32'h0, 1'b1);
        drive(32'h0, 1'b1);
        drive(32'h0, 1'b1);

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired, expected run to finish");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule